// File: doc/BRIEF.md
# Packed Word Blend Execution Unit

This unit merges two 256-bit vector operands one 16-bit word at a time under an 8-bit immediate mask. In each word position a set mask bit takes the word from the second operand and a clear bit takes it from the first. The low 128-bit lane always follows this rule. What the upper lane holds depends on the operating form chosen for the request.

The unit has three forms. The legacy two-operand form treats the first operand as the old destination value, so the upper lane passes through unchanged. The three-operand 128-bit form clears the upper lane. The three-operand 256-bit form applies the same eight mask bits again to the upper lane. The 256-bit form is legal only while a capability input is set. A request for it without the capability, or a request that uses the reserved mode code, raises an undefined-opcode fault instead of producing a result.

Results are registered and appear one clock after the request. The unit drives no arithmetic status flags and raises no floating-point exceptions.

Top module: `wblend_unit`

## Requirements
- R1: For each word i from 0 to 7 of the low lane (bits 16*i+15 down to 16*i), the result word equals the `op_b` word when `imm_mask[i]` is 1 and the `op_a` word when it is 0.
- R2: In legacy mode (`mode` = 2'b00), result bits 255:128 equal `op_a` bits 255:128, the prior destination value, unchanged.
- R3: In three-operand 128-bit mode (`mode` = 2'b01), result bits 255:128 are zero.
- R4: In 256-bit mode (`mode` = 2'b10) with `wide_en` high, `imm_mask[i]` also selects word i+8 (bits 16*(i+8)+15 down to 16*(i+8)): the word comes from `op_b` when the bit is 1 and from `op_a` when it is 0.
- R5: A 256-bit request while `wide_en` is low raises `ud_fault` one clock later and leaves `res_valid` low, and `res_data` keeps its previous value.
- R6: The reserved mode code 2'b11 raises `ud_fault` whatever the value of `wide_en`, with `res_valid` low and `res_data` held.
- R7: An accepted request raises `res_valid` for exactly one clock, one clock after `in_valid`. A cycle without `in_valid` gives `res_valid` and `ud_fault` low and leaves `res_data` unchanged.
- R8: A synchronous active-high `rst` clears `res_data`, `res_valid` and `ud_fault` to zero.
- R9: `res_valid` and `ud_fault` are never high in the same cycle, and each fault pulse lasts one clock per faulting request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| mode | input | 2 | Operating form: 00 legacy, 01 three-operand 128-bit, 10 three-operand 256-bit, 11 reserved |
| wide_en | input | 1 | Capability flag; the 256-bit form is allowed only while it is high |
| imm_mask | input | 8 | Per-word select mask |
| op_a | input | 256 | First source; in legacy mode, the prior destination value |
| op_b | input | 256 | Second source |
| res_data | output | 256 | Registered result |
| res_valid | output | 1 | Result strobe, one clock after an accepted request |
| ud_fault | output | 1 | Undefined-opcode fault, one clock after a rejected request |

## Verification
The masks all-zero and all-one show whether either source reaches every word position. The alternating masks 8'hAA and 8'h55 and the single-bit masks 8'h01 and 8'h80 show whether the bit-to-word order is correct or reversed. Every mask is tried in all three legal forms, which shows whether the upper lane is passed through, cleared or blended with the mask reused. Faulting requests, with the capability flag both set and clear, are placed between valid requests and idle cycles. A held result can then be told apart from one that was overwritten or cleared.

// File: rtl/wblend_pkg.sv
package wblend_pkg;

    typedef enum logic [1:0] {
        MODE_LEG128 = 2'b00,
        MODE_TRI128 = 2'b01,
        MODE_TRI256 = 2'b10,
        MODE_RSVD   = 2'b11
    } wb_mode_e;

    typedef enum logic [1:0] {
        UP_KEEP  = 2'b00,
        UP_ZERO  = 2'b01,
        UP_BLEND = 2'b10
    } up_sel_e;

endpackage

// File: rtl/wblend_lane.sv
module wblend_lane #(
    parameter int WORD_W = 16,
    parameter int WORDS  = 8
) (
    input  logic [WORD_W*WORDS-1:0] lane_a,
    input  logic [WORD_W*WORDS-1:0] lane_b,
    input  logic [WORDS-1:0]        sel,
    output logic [WORD_W*WORDS-1:0] lane_y
);

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        assign lane_y[w*WORD_W +: WORD_W] = sel[w] ? lane_b[w*WORD_W +: WORD_W]
                                                   : lane_a[w*WORD_W +: WORD_W];
    end

endmodule

// File: rtl/wblend_dec.sv
module wblend_dec
    import wblend_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       wide_en,
    output logic       illegal,
    output up_sel_e    up_sel
);

    always_comb begin
        illegal = 1'b0;
        up_sel  = UP_KEEP;
        unique case (wb_mode_e'(mode))
            MODE_LEG128: up_sel = UP_KEEP;
            MODE_TRI128: up_sel = UP_ZERO;
            MODE_TRI256: begin
                up_sel  = UP_BLEND;
                illegal = ~wide_en;
            end
            default:     illegal = 1'b1;
        endcase
    end

endmodule

// File: rtl/wblend_unit.sv
module wblend_unit
    import wblend_pkg::*;
#(
    parameter int WORD_W     = 16,
    parameter int LANE_WORDS = 8
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               in_valid,
    input  logic [1:0]                         mode,
    input  logic                               wide_en,
    input  logic [LANE_WORDS-1:0]              imm_mask,
    input  logic [2*WORD_W*LANE_WORDS-1:0]     op_a,
    input  logic [2*WORD_W*LANE_WORDS-1:0]     op_b,
    output logic [2*WORD_W*LANE_WORDS-1:0]     res_data,
    output logic                               res_valid,
    output logic                               ud_fault
);

    localparam int LANE_W = WORD_W * LANE_WORDS;
    localparam int NLANES = 2;
    localparam int VEC_W  = LANE_W * NLANES;

    typedef struct packed {
        logic [VEC_W-1:0] res;
        logic             vld;
        logic             flt;
    } st_t;

    st_t st_d, st_q;

    logic    illegal;
    up_sel_e up_sel;
    logic [LANE_W-1:0] blend [NLANES];
    logic [LANE_W-1:0] upper;

    wblend_dec u_dec (
        .mode    (mode),
        .wide_en (wide_en),
        .illegal (illegal),
        .up_sel  (up_sel)
    );

    for (genvar l = 0; l < NLANES; l++) begin : g_lane
        wblend_lane #(.WORD_W(WORD_W), .WORDS(LANE_WORDS)) u_lane (
            .lane_a (op_a[l*LANE_W +: LANE_W]),
            .lane_b (op_b[l*LANE_W +: LANE_W]),
            .sel    (imm_mask),
            .lane_y (blend[l])
        );
    end

    always_comb begin
        unique case (up_sel)
            UP_ZERO:  upper = '0;
            UP_BLEND: upper = blend[1];
            default:  upper = op_a[VEC_W-1:LANE_W];
        endcase
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        st_d.flt = 1'b0;
        if (in_valid) begin
            if (illegal) begin
                st_d.flt = 1'b1;
            end else begin
                st_d.vld = 1'b1;
                st_d.res = {upper, blend[0]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign res_data  = st_q.res;
    assign res_valid = st_q.vld;
    assign ud_fault  = st_q.flt;

    // R9: a cycle never carries both a result and a fault
    p_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(res_valid && ud_fault));

    // R5: a 256-bit request without the capability faults
    p_wide_fault_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 2'b10 && !wide_en) |=> (ud_fault && !res_valid));

    // R6: the reserved code faults
    p_rsvd_fault_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 2'b11) |=> (ud_fault && !res_valid));

    // R5/R6: the result holds across a fault
    p_hold_fault_r5: assert property (@(posedge clk) disable iff (rst)
        ud_fault |-> $stable(res_data));

    // R7: no request gives no strobe and a held result
    p_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!res_valid && !ud_fault && $stable(res_data)));

    // R3: the upper lane is cleared in three-operand 128-bit mode
    p_zero_up_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 2'b01) |=> (res_valid && res_data[VEC_W-1:LANE_W] == '0));

    // R2: the upper lane passes through in legacy mode
    p_keep_up_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 2'b00) |=>
            (res_valid && res_data[VEC_W-1:LANE_W] == $past(op_a[VEC_W-1:LANE_W])));

endmodule

// File: tb/wblend_unit_tb.sv
module wblend_unit_tb;

    localparam int VW = 256;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic [1:0]    mode;
    logic          wide_en;
    logic [7:0]    imm_mask;
    logic [VW-1:0] op_a, op_b;
    logic [VW-1:0] res_data;
    logic          res_valid, ud_fault;

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct {
        logic          v;
        logic          f;
        logic [VW-1:0] d;
        string         req;
    } exp_t;

    exp_t exp_q[$];
    logic [VW-1:0] model_res;

    always #10 clk = ~clk;

    wblend_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .wide_en(wide_en),
        .imm_mask(imm_mask), .op_a(op_a), .op_b(op_b),
        .res_data(res_data), .res_valid(res_valid), .ud_fault(ud_fault)
    );

    task automatic check1(input string req, input string what,
                          input logic [VW-1:0] act, input logic [VW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [VW-1:0] mk_vec(input logic [7:0] tag, input int seed);
        logic [VW-1:0] v;
        for (int w = 0; w < 16; w++)
            v[w*16 +: 16] = {tag, 8'(w * 17 + seed * 5)};
        return v;
    endfunction

    // monitor: compare outputs with the queued expectation once per clock
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check1(e.req, "res_valid", VW'(res_valid), VW'(e.v));
            check1(e.req, "ud_fault",  VW'(ud_fault),  VW'(e.f));
            check1(e.req, "res_data",  res_data,       e.d);
        end
    end

    task automatic issue(input logic v, input logic [1:0] m, input logic cap,
                         input logic [7:0] msk, input int seed, input string req);
        exp_t e;
        logic [VW-1:0] a, b, r;
        a = mk_vec(8'hA5, seed);
        b = mk_vec(8'h3C, seed + 3);
        @(negedge clk);
        in_valid = v; mode = m; wide_en = cap; imm_mask = msk; op_a = a; op_b = b;
        e.req = req;
        e.v = 1'b0; e.f = 1'b0;
        if (v) begin
            if (m == 2'b11 || (m == 2'b10 && !cap)) begin
                e.f = 1'b1;                                   // R5 R6
            end else begin
                e.v = 1'b1;
                for (int w = 0; w < 8; w++)                   // R1
                    r[w*16 +: 16] = msk[w] ? b[w*16 +: 16] : a[w*16 +: 16];
                for (int w = 8; w < 16; w++) begin
                    if (m == 2'b00)      r[w*16 +: 16] = a[w*16 +: 16];   // R2
                    else if (m == 2'b01) r[w*16 +: 16] = 16'h0;           // R3
                    else r[w*16 +: 16] = msk[w-8] ? b[w*16 +: 16] : a[w*16 +: 16]; // R4
                end
                model_res = r;
            end
        end
        e.d = model_res;
        @(posedge clk);
        #1 exp_q.push_back(e);
    endtask

    initial begin
        #4_000_000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] masks [6] = '{8'h00, 8'hFF, 8'hAA, 8'h55, 8'h01, 8'h80};
        model_res = '0;
        rst = 1'b1; in_valid = 1'b1; mode = 2'b10; wide_en = 1'b1;
        imm_mask = 8'hFF; op_a = '1; op_b = '1;
        repeat (3) @(negedge clk);
        // R8: reset clears everything even with a request present
        check1("R8", "res_data",  res_data, '0);
        check1("R8", "res_valid", VW'(res_valid), '0);
        check1("R8", "ud_fault",  VW'(ud_fault), '0);
        rst = 1'b0; in_valid = 1'b0;

        for (int m = 0; m < 3; m++)
            for (int k = 0; k < 6; k++)
                issue(1'b1, 2'(m), 1'b1, masks[k], m * 6 + k,
                      m == 0 ? "R1/R2" : (m == 1 ? "R1/R3" : "R1/R4"));

        // R5: 256-bit without capability, between valid results
        issue(1'b1, 2'b00, 1'b1, 8'h3C, 40, "R2");
        issue(1'b1, 2'b10, 1'b0, 8'hFF, 41, "R5");
        issue(1'b0, 2'b00, 1'b0, 8'h00, 42, "R7");
        issue(1'b1, 2'b10, 1'b0, 8'h0F, 43, "R5");
        issue(1'b1, 2'b10, 1'b0, 8'hF0, 44, "R9");
        // R6: reserved code with and without capability
        issue(1'b1, 2'b11, 1'b1, 8'hFF, 45, "R6");
        issue(1'b1, 2'b11, 1'b0, 8'hAA, 46, "R6");
        issue(1'b1, 2'b01, 1'b1, 8'hC3, 47, "R3");
        // R7: idle cycles hold the result and keep strobes low
        issue(1'b0, 2'b10, 1'b1, 8'hFF, 48, "R7");
        issue(1'b0, 2'b01, 1'b1, 8'h00, 49, "R7");
        issue(1'b1, 2'b10, 1'b1, 8'h96, 50, "R4");
        issue(1'b1, 2'b10, 1'b0, 8'h69, 51, "R9");
        issue(1'b0, 2'b00, 1'b0, 8'h00, 52, "R7");
        issue(1'b0, 2'b00, 1'b0, 8'h00, 53, "R7");
        repeat (3) @(negedge clk);

        // R8: reset mid-stream clears a held result
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        check1("R8", "res_data mid-stream", res_data, '0);
        rst = 1'b0;

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule